// File: doc/BRIEF.md
# Flash Status Register Protection Logic

This block keeps the status bits of a serial NOR flash and decides, for each decoded write-register command, whether the write goes through. The decision depends on four inputs. The first is a two-bit protect mode held in the register itself. The second is the write-enable latch. The third is the level of the write-protect pin. The fourth is the quad-enable bit. When quad mode is on, the write-protect pin is used as a data line. The block also holds three one-time lock bits for the security registers, a complement bit for the array protection, and a read-only suspend flag. The suspend flag is driven by the suspend and resume command strobes.

The bits are non-volatile. `rst_n` models the first power-up of a blank part and loads factory defaults. `pwr_cycle` models a later power-down and power-up. It clears only the volatile parts: the suspend flag, and the "locked until next power cycle" protect mode. Every accepted write produces a one-cycle accept pulse and a strobe that tells the command logic to clear its write-enable latch. Every rejected write produces a one-cycle reject pulse instead.

Top module: `srp_ctrl`

## Requirements
- R1: After `rst_n` is low, `sr_q` is 0x0000 and `wr_accept`, `wr_reject` and `wel_clear` are 0. The register layout is fixed as follows. Bits 6:0 are general read/write bits. Bit 7 is protect-mode low and bit 8 is protect-mode high. Bit 9 is quad enable. Bit 10 always reads 0. Bits 11, 12 and 13 are lock bits 1, 2 and 3. Bit 14 is CMP. Bit 15 is SUS.
- R2: In protect mode 00, a write is accepted exactly when `wel` is 1, whatever the level of `wp_n`.
- R3: In protect mode 01, with quad enable 0 and `wp_n` low, every write is rejected.
- R4: In protect mode 01, with `wp_n` high, a write is accepted when `wel` is 1.
- R5: In protect mode 10, every write is rejected. A `pwr_cycle` pulse changes the mode to 00.
- R6: In protect mode 11, every write is rejected, and `pwr_cycle` does not change the mode.
- R7: An accepted write can set each lock bit (bits 13:11) to 1 independently. A lock bit that is 1 never returns to 0. `sec_ro[i]` shows lock bit i+1.
- R8: CMP (bit 14) is 0 after reset and takes the written value on an accepted write.
- R9: SUS (bit 15) is set by `sus_cmd`, cleared by `res_cmd` or by `pwr_cycle`, and ignores write data. When `sus_cmd` and `res_cmd` arrive together, `sus_cmd` wins.
- R10: `io2_is_data` and `io3_is_data` follow quad enable (bit 9). While quad enable is 1, `wp_n` is treated as high for the protect decision.
- R11: A write is answered one cycle later by exactly one of two outcomes. An accepted write raises `wr_accept` together with `wel_clear` for one cycle. A rejected write raises `wr_reject` for one cycle and leaves every bit except SUS unchanged.
- R12: `pwr_cycle` keeps bits 14:9 and 6:0, and the mode unless it is 10. A write in the same cycle as `pwr_cycle` is dropped, with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset that loads factory defaults |
| pwr_cycle | input | 1 | Synchronous power-cycle event |
| wr_valid | input | 1 | Decoded write-register command strobe |
| wr_data | input | 16 | Write data in the same layout as `sr_q` |
| wel | input | 1 | Write-enable latch level |
| wp_n | input | 1 | Write-protect pin level (active low) |
| sus_cmd | input | 1 | Suspend command strobe |
| res_cmd | input | 1 | Resume command strobe |
| sr_q | output | 16 | Current status register contents |
| wr_accept | output | 1 | One-cycle pulse: write accepted |
| wr_reject | output | 1 | One-cycle pulse: write rejected |
| wel_clear | output | 1 | One-cycle strobe to clear the write-enable latch |
| io2_is_data | output | 1 | Extra pin 2 acts as a data line |
| io3_is_data | output | 1 | Extra pin 3 acts as a data line |
| sec_ro | output | 3 | Security register i+1 is read-only |

## Verification
Several rules are checked on every cycle:
- the permanent lock never accepts a write;
- a pin-locked write with quad enable off is always rejected;
- a write without `wel` is rejected;
- lock bits only rise;
- a rejected write changes nothing;
- a power cycle clears SUS and releases mode 10.

Some behaviour can only be shown by the bench's reference model across its scenarios:
- the exact data an accepted write stores;
- the quad-enable override of the pin;
- the priority between suspend and resume;
- the fact that the permanent lock survives power cycles.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
    localparam int SR_W      = 16;
    localparam int GEN_W     = 7;
    localparam int NUM_LOCKS = 3;
    localparam int POS_MLO   = GEN_W;
    localparam int POS_MHI   = POS_MLO + 1;
    localparam int POS_QE    = POS_MHI + 1;
    localparam int POS_RSV   = POS_QE + 1;
    localparam int POS_LOCK  = POS_RSV + 1;
    localparam int POS_CMP   = POS_LOCK + NUM_LOCKS;
    localparam int POS_SUS   = POS_CMP + 1;

    typedef enum logic [1:0] {
        PM_SOFT      = 2'b00,
        PM_PIN       = 2'b01,
        PM_UNTIL_PWR = 2'b10,
        PM_FOREVER   = 2'b11
    } prot_mode_e;

    typedef struct packed {
        logic [GEN_W-1:0]     gen;
        prot_mode_e           mode;
        logic                 qe;
        logic [NUM_LOCKS-1:0] lock;
        logic                 cmp;
        logic                 sus;
        logic                 acc;
        logic                 rej;
    } srp_state_t;
endpackage

// File: rtl/srp_pinmux.sv
`timescale 1ns/1ps
module srp_pinmux (
    input  logic qe,
    input  logic wp_n_pin,
    output logic wp_n_eff,
    output logic io2_data,
    output logic io3_data
);
    // With quad on, the pin carries data, so protection sees it as inactive.
    assign wp_n_eff = qe | wp_n_pin;
    assign io2_data = qe;
    assign io3_data = qe;
endmodule

// File: rtl/srp_gate.sv
`timescale 1ns/1ps
module srp_gate
    import srp_pkg::*;
(
    input  prot_mode_e mode,
    input  logic       wel,
    input  logic       wp_n_eff,
    input  logic       wr_valid,
    input  logic       pwr_cycle,
    output logic       accept,
    output logic       reject
);
    logic permit;

    always_comb begin
        unique case (mode)
            PM_SOFT: permit = wel;
            PM_PIN:  permit = wel & wp_n_eff;
            default: permit = 1'b0;
        endcase
    end

    assign accept = wr_valid & ~pwr_cycle &  permit;
    assign reject = wr_valid & ~pwr_cycle & ~permit;
endmodule

// File: rtl/srp_otp.sv
`timescale 1ns/1ps
module srp_otp #(
    parameter int N = 3
) (
    input  logic [N-1:0] lock_q,
    input  logic         set_en,
    input  logic [N-1:0] set_data,
    output logic [N-1:0] lock_d
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign lock_d[i] = lock_q[i] | (set_en & set_data[i]);
    end
endmodule

// File: rtl/srp_ctrl.sv
`timescale 1ns/1ps
module srp_ctrl
    import srp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_cycle,
    input  logic                 wr_valid,
    input  logic [SR_W-1:0]      wr_data,
    input  logic                 wel,
    input  logic                 wp_n,
    input  logic                 sus_cmd,
    input  logic                 res_cmd,
    output logic [SR_W-1:0]      sr_q,
    output logic                 wr_accept,
    output logic                 wr_reject,
    output logic                 wel_clear,
    output logic                 io2_is_data,
    output logic                 io3_is_data,
    output logic [NUM_LOCKS-1:0] sec_ro
);
    srp_state_t           st_q, st_d;
    logic                 wp_n_eff, accept, reject;
    logic [NUM_LOCKS-1:0] lock_nxt;

    srp_pinmux u_pinmux (
        .qe       (st_q.qe),
        .wp_n_pin (wp_n),
        .wp_n_eff (wp_n_eff),
        .io2_data (io2_is_data),
        .io3_data (io3_is_data)
    );

    srp_gate u_gate (
        .mode      (st_q.mode),
        .wel       (wel),
        .wp_n_eff  (wp_n_eff),
        .wr_valid  (wr_valid),
        .pwr_cycle (pwr_cycle),
        .accept    (accept),
        .reject    (reject)
    );

    srp_otp #(.N(NUM_LOCKS)) u_otp (
        .lock_q   (st_q.lock),
        .set_en   (accept),
        .set_data (wr_data[POS_LOCK +: NUM_LOCKS]),
        .lock_d   (lock_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.acc  = accept;
        st_d.rej  = reject;
        st_d.lock = lock_nxt;
        if (pwr_cycle) begin
            if (st_q.mode == PM_UNTIL_PWR) st_d.mode = PM_SOFT;
            st_d.sus = 1'b0;
        end else begin
            if (accept) begin
                st_d.gen  = wr_data[GEN_W-1:0];
                st_d.mode = prot_mode_e'({wr_data[POS_MHI], wr_data[POS_MLO]});
                st_d.qe   = wr_data[POS_QE];
                st_d.cmp  = wr_data[POS_CMP];
            end
            if (sus_cmd)      st_d.sus = 1'b1;
            else if (res_cmd) st_d.sus = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_q      = {st_q.sus, st_q.cmp, st_q.lock, 1'b0, st_q.qe, st_q.mode, st_q.gen};
    assign wr_accept = st_q.acc;
    assign wr_reject = st_q.rej;
    assign wel_clear = st_q.acc;
    assign sec_ro    = st_q.lock;
endmodule

// File: rtl/srp_ctrl_chk.sv
`timescale 1ns/1ps
module srp_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_cycle,
    input logic        wr_valid,
    input logic        wel,
    input logic        wp_n,
    input logic [15:0] sr_q,
    input logic        wr_accept,
    input logic        wr_reject
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && wr_reject)); // R11
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> sr_q[14:0] == $past(sr_q[14:0])); // R11
    AST_NO_WEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wel && !pwr_cycle |=> wr_reject); // R2
    AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !pwr_cycle && sr_q[8:7] == 2'b01 && !sr_q[9] && !wp_n |=> wr_reject); // R3
    AST_UNTIL_PWR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle && sr_q[8:7] == 2'b10 |=> sr_q[8:7] == 2'b00); // R5
    AST_FOREVER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q[8:7] == 2'b11 |=> sr_q[8:7] == 2'b11 && !wr_accept); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q[13:11] & $past(sr_q[13:11])) == $past(sr_q[13:11])); // R7
    AST_PWR_CLEARS_SUS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |=> !sr_q[15] && !wr_accept && !wr_reject); // R9
endmodule

bind srp_ctrl srp_ctrl_chk u_chk (.*);

// File: tb/srp_ctrl_tb.sv
`timescale 1ns/1ps
module srp_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_cycle = 1'b0, wr_valid = 1'b0, wel = 1'b0, wp_n = 1'b1;
    logic        sus_cmd = 1'b0, res_cmd = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] sr_q;
    logic        wr_accept, wr_reject, wel_clear, io2_is_data, io3_is_data;
    logic [2:0]  sec_ro;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;
    logic [15:0] m_sr = '0;
    logic        m_acc = 1'b0, m_rej = 1'b0;

    always #2.5 clk = ~clk;

    srp_ctrl u_dut (.*);

    task automatic compare(input string req);
        logic [25:0] act, exp;
        act = {sr_q, wr_accept, wr_reject, wel_clear, io2_is_data, io3_is_data, sec_ro, 2'b00};
        exp = {m_sr, m_acc, m_rej, m_acc, m_sr[9], m_sr[9], m_sr[13:11], 2'b00};
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h (sr act %h exp %h)", req, act, exp, sr_q, m_sr);
        end
    endtask

    task automatic model_step();
        logic ok;
        m_acc = 1'b0;
        m_rej = 1'b0;
        if (pwr_cycle) begin
            if (m_sr[8:7] == 2'd2) m_sr[8:7] = 2'd0;
            m_sr[15] = 1'b0;
        end else begin
            if (wr_valid) begin
                ok = wel && (m_sr[8:7] == 2'd0 || (m_sr[8:7] == 2'd1 && (m_sr[9] || wp_n)));
                if (ok) begin
                    m_sr[9:0]   = wr_data[9:0];
                    m_sr[13:11] = m_sr[13:11] | wr_data[13:11];
                    m_sr[14]    = wr_data[14];
                    m_acc       = 1'b1;
                end else m_rej = 1'b1;
            end
            if (sus_cmd)      m_sr[15] = 1'b1;
            else if (res_cmd) m_sr[15] = 1'b0;
        end
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(req);
        wr_valid = 0; pwr_cycle = 0; sus_cmd = 0; res_cmd = 0;
    endtask

    task automatic wr(input logic [15:0] d, input logic e, input logic p, input string req);
        wr_data = d; wel = e; wp_n = p; wr_valid = 1'b1;
        cyc(req);
        cyc(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        cyc("R1");
        // R2: mode 00, no wel rejects; wel with pin low accepts
        wr(16'h407F, 1'b0, 1'b1, "R2");
        wr(16'h407F, 1'b1, 1'b0, "R2");
        // R8: CMP back to zero
        wr(16'h0011, 1'b1, 1'b1, "R8");
        // R7: lock bits set and stay set
        wr(16'h0800, 1'b1, 1'b1, "R7");
        wr(16'h0000, 1'b1, 1'b1, "R7");
        wr(16'h2000, 1'b1, 1'b1, "R7");
        // R3/R4: pin mode
        wr(16'h0085, 1'b1, 1'b1, "R4");
        wr(16'h0000, 1'b1, 1'b0, "R3");
        wr(16'h0086, 1'b1, 1'b1, "R4");
        // R10: quad on overrides pin
        wr(16'h0280, 1'b1, 1'b1, "R10");
        wr(16'h0281, 1'b1, 1'b0, "R10");
        wr(16'h0080, 1'b1, 1'b0, "R10");
        wr(16'h0000, 1'b1, 1'b0, "R3");
        // R9: suspend / resume / priority / write data ignored
        sus_cmd = 1; cyc("R9");
        wr(16'h0080, 1'b1, 1'b1, "R9");
        res_cmd = 1; cyc("R9");
        sus_cmd = 1; res_cmd = 1; cyc("R9");
        wr(16'h8080, 1'b1, 1'b1, "R9");
        // R5: lock until power cycle
        wr(16'h4103, 1'b1, 1'b1, "R5");
        wr(16'h0000, 1'b1, 1'b1, "R5");
        sus_cmd = 1; cyc("R9");
        // R12: write during power cycle dropped, other bits kept
        pwr_cycle = 1; wr_valid = 1; wr_data = 16'h0000; wel = 1; cyc("R12");
        cyc("R5");
        wr(16'h0005, 1'b1, 1'b0, "R5");
        pwr_cycle = 1; cyc("R12");
        // R6: permanent lock survives power cycles
        wr(16'h4187, 1'b1, 1'b1, "R6");
        wr(16'h0000, 1'b1, 1'b1, "R6");
        pwr_cycle = 1; cyc("R6");
        wr(16'h0000, 1'b1, 1'b1, "R6");
        // R11: random traffic from a fresh part
        rst_n = 1'b0; m_sr = '0; m_acc = 0; m_rej = 0;
        @(negedge clk); compare("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 600; i++) begin
            wr_valid  = ($urandom_range(0, 2) == 0);
            wr_data   = 16'($urandom) & 16'h7BFF;
            if ((wr_data[8:7] == 2'b11) && i < 500) wr_data[8] = 1'b0;
            wel       = ($urandom_range(0, 3) != 0);
            wp_n      = $urandom_range(0, 1) == 1;
            sus_cmd   = ($urandom_range(0, 7) == 0);
            res_cmd   = ($urandom_range(0, 7) == 0);
            pwr_cycle = ($urandom_range(0, 19) == 0);
            cyc("R11");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule